// File: doc/BRIEF.md
# ADC Trigger List Sequencer

The sequencer sits between a PWM timer and two analog-to-digital converters. The timer raises two flags. The current flag always requests one conversion of the DC-link current channel on converter 0. The list flag steps through the active command list. Each command carries a converter target mask, so one trigger can start both converters in the same cycle. The sequencer clears each flag by pulsing an acknowledge, and it does so whether it starts conversions or turns the trigger down.

Three command lists are built from parameters. Each has two items, and the second item is marked last. Software picks a list with a select input, normally after each commutation so that the floating phase's back-EMF channel is sampled. A new selection is taken up only when the list pointer is at the first item.

Each converter result goes to a per-converter result register and into a small FIFO as a {converter, channel, data} entry. A one-cycle end-of-list pulse follows the completion of a last item. A trigger that cannot be served increments a saturating overrun counter. A result that finds the FIFO full is dropped and sets a sticky overflow flag.

Top module: `adc_list_seq`

## Requirements
- R1: After reset the sequencer is idle. No start is asserted, both acknowledges and the end-of-list pulse are low, the FIFO is empty, and the overrun counter, the overflow flag and both result registers are zero.
- R2: A current flag that is sampled high while idle is acknowledged, and in the next cycle it starts converter 0 alone on channel 8 (CUR_CH).
- R3: For list L (0..2), item 0 has mask 2'b11, where bit 0 selects converter 0 and bit 1 selects converter 1. It starts converter 0 on channel 16+L and converter 1 on channel 18. Item 1 has mask 2'b10, starts converter 1 alone on channel 24+L, and is marked last.
- R4: When every conversion of a last item is done, the end-of-list output is high for exactly one cycle, and the next list trigger runs item 0 again.
- R5: The list select is sampled only when a list trigger is accepted at item 0. A change made in the middle of a list does not affect the remaining items. A select value of 3 chooses list 2.
- R6: A flag that is high while conversions are pending is acknowledged, adds one to the overrun counter, and starts nothing.
- R7: If both flags are high in the same idle cycle, the current trigger is served. The list trigger is acknowledged and counted as an overrun, and the list pointer does not move.
- R8: Each completed conversion updates that converter's result register and pushes {conv, ch, data} into the FIFO. When both converters finish in the same cycle, the converter 0 entry is pushed first.
- R9: A result that arrives while the FIFO holds FIFO_DEPTH entries at the start of the cycle is dropped, and the overflow flag is set and stays set. The result register is still updated.
- R10: A done pulse from a converter with no pending conversion is ignored. Its result register does not change and nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_flag_i | input | 1 | Current-sample trigger flag from the timer |
| list_flag_i | input | 1 | List-step trigger flag from the timer |
| cur_ack_o | output | 1 | Clear pulse for the current flag |
| list_ack_o | output | 1 | Clear pulse for the list flag |
| list_sel_i | input | 2 | Requested command list |
| adc0_start_o | output | 1 | Start pulse, converter 0 |
| adc0_ch_o | output | 5 | Channel for converter 0 |
| adc0_done_i | input | 1 | Conversion done, converter 0 |
| adc0_data_i | input | 12 | Conversion data, converter 0 |
| adc1_start_o | output | 1 | Start pulse, converter 1 |
| adc1_ch_o | output | 5 | Channel for converter 1 |
| adc1_done_i | input | 1 | Conversion done, converter 1 |
| adc1_data_i | input | 12 | Conversion data, converter 1 |
| res0_o | output | 12 | Latest result from converter 0 |
| res1_o | output | 12 | Latest result from converter 1 |
| fifo_valid_o | output | 1 | FIFO holds at least one entry |
| fifo_conv_o | output | 1 | Converter of the FIFO head entry |
| fifo_ch_o | output | 5 | Channel of the FIFO head entry |
| fifo_data_o | output | 12 | Data of the FIFO head entry |
| fifo_pop_i | input | 1 | Remove the FIFO head entry |
| eol_o | output | 1 | End-of-list pulse |
| overrun_cnt_o | output | 8 | Saturating count of refused triggers |
| fifo_ovf_o | output | 1 | Sticky FIFO overflow flag |

## Verification
The following properties are checked on every cycle:
- starts occur only after an idle cycle;
- converter 1 is never started by the current trigger, and that trigger uses the fixed channel;
- the end-of-list pulse coincides with the return to idle and a pointer at zero;
- a busy-time flag raises the overrun count;
- stray done pulses leave the result registers unchanged;
- the FIFO count stays within bounds, and the overflow flag is sticky.

Only the bench scenarios can show that the channel sequence matches the selected list, including a select change in the middle of a list and the clamped value 3. They also show the converter order of entries from a paired conversion, the simultaneous-flag priority, and which entries survive a FIFO overflow.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic {S_IDLE, S_BUSY} seq_state_e;

  typedef struct packed {
    logic [1:0] mask;  // bit0 converter 0, bit1 converter 1
    logic       last;
  } cmd_ctl_t;
endpackage

// File: rtl/seq_cmd_table.sv
module seq_cmd_table
  import adcseq_pkg::*;
#(
  parameter int N_LISTS   = 3,
  parameter int N_ITEMS   = 2,
  parameter int CH_W      = 5,
  parameter int BEMF_BASE = 16,
  parameter int VBUS_CH   = 18,
  parameter int AUX_BASE  = 24,
  localparam int LW = (N_LISTS > 1) ? $clog2(N_LISTS) : 1,
  localparam int IW = (N_ITEMS > 1) ? $clog2(N_ITEMS) : 1
) (
  input  logic [LW-1:0]   list_i,
  input  logic [IW-1:0]   item_i,
  output cmd_ctl_t        ctl_o,
  output logic [CH_W-1:0] ch0_o,
  output logic [CH_W-1:0] ch1_o
);
  localparam int N_CMD = N_LISTS * N_ITEMS;

  cmd_ctl_t        tbl_ctl [N_CMD];
  logic [CH_W-1:0] tbl_ch0 [N_CMD];
  logic [CH_W-1:0] tbl_ch1 [N_CMD];

  for (genvar l = 0; l < N_LISTS; l++) begin : g_list
    for (genvar i = 0; i < N_ITEMS; i++) begin : g_item
      localparam logic [CH_W-1:0] C0 = CH_W'(BEMF_BASE + l);
      localparam logic [CH_W-1:0] C1 = (i == 0) ? CH_W'(VBUS_CH) : CH_W'(AUX_BASE + l);
      assign tbl_ctl[l*N_ITEMS+i].mask = (i == 0) ? 2'b11 : 2'b10;
      assign tbl_ctl[l*N_ITEMS+i].last = (i == N_ITEMS - 1);
      assign tbl_ch0[l*N_ITEMS+i]      = C0;
      assign tbl_ch1[l*N_ITEMS+i]      = C1;
    end
  end

  always_comb begin
    int idx;
    idx = int'(list_i) * N_ITEMS + int'(item_i);
    if (idx >= N_CMD) idx = 0;
    ctl_o = tbl_ctl[idx];
    ch0_o = tbl_ch0[idx];
    ch1_o = tbl_ch1[idx];
  end
endmodule

// File: rtl/seq_result_fifo.sv
// Two write ports per cycle (port 0 lands first); DEPTH must be a power of two.
module seq_result_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push0_i,
  input  logic [W-1:0] d0_i,
  input  logic         push1_i,
  input  logic [W-1:0] d1_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] head_o,
  output logic         ovf_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          acc0, acc1, pop_ok;

  assign acc0   = push0_i && (cnt_q < CW'(DEPTH));
  assign acc1   = push1_i && ((cnt_q + CW'(acc0)) < CW'(DEPTH));
  assign pop_ok = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (acc0) mem[wp_q] <= d0_i;
    if (acc1) mem[wp_q + AW'(acc0)] <= d1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_q + AW'(acc0) + AW'(acc1);
      rp_q  <= rp_q + AW'(pop_ok);
      cnt_q <= cnt_q + CW'(acc0) + CW'(acc1) - CW'(pop_ok);
      if ((push0_i && !acc0) || (push1_i && !acc1)) ovf_q <= 1'b1;
    end
  end

  assign valid_o = (cnt_q != '0);
  assign head_o  = mem[rp_q];
  assign ovf_o   = ovf_q;

  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/adc_list_seq.sv
module adc_list_seq
  import adcseq_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int CH_W       = 5,
  parameter int N_LISTS    = 3,
  parameter int N_ITEMS    = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int CUR_CH     = 8,
  parameter int BEMF_BASE  = 16,
  parameter int VBUS_CH    = 18,
  parameter int AUX_BASE   = 24,
  parameter int OVR_W      = 8,
  localparam int LW = (N_LISTS > 1) ? $clog2(N_LISTS) : 1,
  localparam int IW = (N_ITEMS > 1) ? $clog2(N_ITEMS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cur_flag_i,
  input  logic              list_flag_i,
  output logic              cur_ack_o,
  output logic              list_ack_o,
  input  logic [LW-1:0]     list_sel_i,
  output logic              adc0_start_o,
  output logic [CH_W-1:0]   adc0_ch_o,
  input  logic              adc0_done_i,
  input  logic [DATA_W-1:0] adc0_data_i,
  output logic              adc1_start_o,
  output logic [CH_W-1:0]   adc1_ch_o,
  input  logic              adc1_done_i,
  input  logic [DATA_W-1:0] adc1_data_i,
  output logic [DATA_W-1:0] res0_o,
  output logic [DATA_W-1:0] res1_o,
  output logic              fifo_valid_o,
  output logic              fifo_conv_o,
  output logic [CH_W-1:0]   fifo_ch_o,
  output logic [DATA_W-1:0] fifo_data_o,
  input  logic              fifo_pop_i,
  output logic              eol_o,
  output logic [OVR_W-1:0]  overrun_cnt_o,
  output logic              fifo_ovf_o
);
  localparam int EW = 1 + CH_W + DATA_W;

  seq_state_e        state_q;
  logic [1:0]        pend_q, start_q, pend_after;
  logic              is_list_q, last_q, eol_q;
  logic              cur_ack_q, list_ack_q;
  logic [IW-1:0]     ptr_q;
  logic [LW-1:0]     act_list_q, sel_eff, list_now;
  logic [CH_W-1:0]   ch0_q, ch1_q, tbl_ch0, tbl_ch1;
  logic [DATA_W-1:0] res0_q, res1_q;
  logic [OVR_W-1:0]  ovr_q;
  logic [OVR_W:0]    ovr_sum;
  logic [1:0]        hits;
  cmd_ctl_t          tbl_ctl;
  logic              idle, cur_req, list_req, take_cur, take_list, hit0, hit1;
  logic [EW-1:0]     head;

  assign idle      = (state_q == S_IDLE);
  assign cur_req   = cur_flag_i && !cur_ack_q;
  assign list_req  = list_flag_i && !list_ack_q;
  assign take_cur  = idle && cur_req;
  assign take_list = idle && list_req && !cur_req;
  assign hits      = 2'(!idle && cur_req) + 2'(!idle && list_req) + 2'(idle && cur_req && list_req);
  assign ovr_sum   = {1'b0, ovr_q} + (OVR_W+1)'(hits);

  assign sel_eff  = (int'(list_sel_i) > N_LISTS - 1) ? LW'(N_LISTS - 1) : list_sel_i;
  assign list_now = (ptr_q == '0) ? sel_eff : act_list_q;

  assign hit0       = adc0_done_i && pend_q[0];
  assign hit1       = adc1_done_i && pend_q[1];
  assign pend_after = pend_q & ~{hit1, hit0};

  seq_cmd_table #(
    .N_LISTS(N_LISTS), .N_ITEMS(N_ITEMS), .CH_W(CH_W),
    .BEMF_BASE(BEMF_BASE), .VBUS_CH(VBUS_CH), .AUX_BASE(AUX_BASE)
  ) u_table (
    .list_i(list_now), .item_i(ptr_q),
    .ctl_o(tbl_ctl), .ch0_o(tbl_ch0), .ch1_o(tbl_ch1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      pend_q     <= '0;
      start_q    <= '0;
      is_list_q  <= 1'b0;
      last_q     <= 1'b0;
      eol_q      <= 1'b0;
      cur_ack_q  <= 1'b0;
      list_ack_q <= 1'b0;
      ptr_q      <= '0;
      act_list_q <= '0;
      ch0_q      <= '0;
      ch1_q      <= '0;
      res0_q     <= '0;
      res1_q     <= '0;
      ovr_q      <= '0;
    end else begin
      // every sampled flag is cleared, served or refused
      cur_ack_q  <= cur_req;
      list_ack_q <= list_req;
      start_q    <= '0;
      eol_q      <= 1'b0;
      ovr_q      <= ovr_sum[OVR_W] ? '1 : ovr_sum[OVR_W-1:0];
      if (hit0) res0_q <= adc0_data_i;
      if (hit1) res1_q <= adc1_data_i;
      if (take_cur) begin
        state_q   <= S_BUSY;
        pend_q    <= 2'b01;
        start_q   <= 2'b01;
        ch0_q     <= CH_W'(CUR_CH);
        is_list_q <= 1'b0;
      end else if (take_list) begin
        state_q   <= S_BUSY;
        pend_q    <= tbl_ctl.mask;
        start_q   <= tbl_ctl.mask;
        ch0_q     <= tbl_ch0;
        ch1_q     <= tbl_ch1;
        is_list_q <= 1'b1;
        last_q    <= tbl_ctl.last;
        ptr_q     <= tbl_ctl.last ? '0 : ptr_q + IW'(1);
        if (ptr_q == '0) act_list_q <= sel_eff;
      end else if (!idle) begin
        pend_q <= pend_after;
        if (pend_after == '0) begin
          state_q <= S_IDLE;
          eol_q   <= is_list_q && last_q;
        end
      end
    end
  end

  seq_result_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push0_i(hit0), .d0_i({1'b0, ch0_q, adc0_data_i}),
    .push1_i(hit1), .d1_i({1'b1, ch1_q, adc1_data_i}),
    .pop_i(fifo_pop_i), .valid_o(fifo_valid_o), .head_o(head), .ovf_o(fifo_ovf_o)
  );

  assign {fifo_conv_o, fifo_ch_o, fifo_data_o} = head;
  assign cur_ack_o     = cur_ack_q;
  assign list_ack_o    = list_ack_q;
  assign adc0_start_o  = start_q[0];
  assign adc1_start_o  = start_q[1];
  assign adc0_ch_o     = ch0_q;
  assign adc1_ch_o     = ch1_q;
  assign res0_o        = res0_q;
  assign res1_o        = res1_q;
  assign eol_o         = eol_q;
  assign overrun_cnt_o = ovr_q;

  p_start_from_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_q) |-> $past(state_q == S_IDLE));
  p_cur_conv0_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc0_start_o && !is_list_q) |-> (!adc1_start_o && adc0_ch_o == CH_W'(CUR_CH)));
  p_eol_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> (ptr_q == '0 && state_q == S_IDLE && $past(state_q == S_BUSY)));
  p_busy_overrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && cur_req && !(&ovr_q)) |=> (ovr_q != $past(ovr_q)));
  p_stray_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc1_done_i && !pend_q[1]) |=> (res1_q == $past(res1_q)));
endmodule

// File: tb/tb_adc_list_seq.sv
`timescale 1ns/1ps
module tb_adc_list_seq;
  localparam int LAT = 4;

  logic clk = 0, rst_n = 0;
  logic cur_flag = 0, list_flag = 0, pop = 0;
  logic [1:0] list_sel = 0;
  logic cur_ack, list_ack, s0, s1, d1_w, fvalid, fconv, eol, ovf;
  logic [4:0] c0, c1, fch;
  logic [11:0] r0, r1, fdata;
  logic [7:0] ovr;
  logic m0_done = 0, m1_done = 0, stray1 = 0;
  logic [11:0] m0_data = 0, m1_data = 0;
  int m0_cnt = 0, m1_cnt = 0, m0_ch = 0, m1_ch = 0;
  int errors = 0, checks = 0, eol_seen = 0, b_ptr = 0, b_list = 0;
  bit mon_en = 1;
  logic [17:0] exp_q[$];

  always #4 clk = ~clk;
  assign d1_w = m1_done | stray1;

  adc_list_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cur_flag_i(cur_flag), .list_flag_i(list_flag),
    .cur_ack_o(cur_ack), .list_ack_o(list_ack), .list_sel_i(list_sel),
    .adc0_start_o(s0), .adc0_ch_o(c0), .adc0_done_i(m0_done), .adc0_data_i(m0_data),
    .adc1_start_o(s1), .adc1_ch_o(c1), .adc1_done_i(d1_w), .adc1_data_i(m1_data),
    .res0_o(r0), .res1_o(r1), .fifo_valid_o(fvalid), .fifo_conv_o(fconv),
    .fifo_ch_o(fch), .fifo_data_o(fdata), .fifo_pop_i(pop), .eol_o(eol),
    .overrun_cnt_o(ovr), .fifo_ovf_o(ovf)
  );

  function automatic logic [11:0] adc_val(input int conv, input int ch);
    return conv != 0 ? 12'(12'h800 + ch * 3) : 12'(12'h100 + ch * 7);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // converter models
  initial forever begin
    @(negedge clk);
    m0_done = 0;
    if (m0_cnt > 0) begin
      m0_cnt--;
      if (m0_cnt == 0) begin m0_done = 1; m0_data = adc_val(0, m0_ch); end
    end
    if (s0) begin m0_ch = int'(c0); m0_cnt = LAT; end
  end
  initial forever begin
    @(negedge clk);
    m1_done = 0;
    if (m1_cnt > 0) begin
      m1_cnt--;
      if (m1_cnt == 0) begin m1_done = 1; m1_data = adc_val(1, m1_ch); end
    end
    if (s1) begin m1_ch = int'(c1); m1_cnt = LAT; end
  end

  // scoreboard monitor (R8)
  initial forever begin
    @(negedge clk);
    if (eol) eol_seen++;
    if (mon_en && fvalid) begin
      if (exp_q.size() == 0) chk(0, "R8", "unexpected fifo entry", int'(fch), -1);
      else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        chk({fconv, fch, fdata} == e, "R8", "fifo entry", int'({fconv, fch, fdata}), int'(e));
      end
      pop = 1;
    end else pop = 0;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic pulse_flags(input bit c, input bit l);
    cur_flag = c; list_flag = l;
    @(negedge clk);
    cur_flag = 0; list_flag = 0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic cur_shot(input bit expect_push);
    if (expect_push) exp_q.push_back({1'b0, 5'd8, adc_val(0, 8)});
    pulse_flags(1, 0);
    chk(cur_ack && s0 && !s1 && c0 == 5'd8, "R2", "single start conv0 ch8", int'(c0), 8);
    settle();
  endtask

  task automatic list_shot();
    int l;
    l = (b_ptr == 0) ? ((list_sel > 2) ? 2 : int'(list_sel)) : b_list;
    if (b_ptr == 0) b_list = l;
    if (b_ptr == 0) begin
      exp_q.push_back({1'b0, 5'(16 + l), adc_val(0, 16 + l)});
      exp_q.push_back({1'b1, 5'd18, adc_val(1, 18)});
    end else exp_q.push_back({1'b1, 5'(24 + l), adc_val(1, 24 + l)});
    pulse_flags(0, 1);
    if (b_ptr == 0)
      chk(list_ack && s0 && s1 && c0 == 5'(16 + l) && c1 == 5'd18, "R3", "item0 starts", int'(c0), 16 + l);
    else
      chk(list_ack && !s0 && s1 && c1 == 5'(24 + l), "R3", "item1 starts", int'(c1), 24 + l);
    b_ptr = (b_ptr == 1) ? 0 : 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!s0 && !s1 && !cur_ack && !list_ack && !eol, "R1", "reset outputs", int'(s0), 0);
    chk(!fvalid && ovr == 0 && !ovf, "R1", "reset fifo/counters", int'(ovr), 0);
    chk(r0 == 0 && r1 == 0, "R1", "reset results", int'(r0), 0);

    cur_shot(1);
    chk(r0 == adc_val(0, 8), "R8", "res0 after single", int'(r0), int'(adc_val(0, 8)));

    list_sel = 0;
    list_shot(); settle();
    chk(eol_seen == 0, "R4", "no eol mid list", eol_seen, 0);
    list_sel = 1;                       // R5: change mid list
    list_shot(); settle();
    chk(eol_seen == 1, "R4", "eol after last item", eol_seen, 1);
    list_shot(); settle();              // list 1 now
    list_shot(); settle();
    chk(eol_seen == 2, "R4", "second eol", eol_seen, 2);
    list_sel = 3;                       // R5: clamps to list 2
    list_shot(); settle();
    list_shot(); settle();

    // R6: trigger while busy
    list_shot();
    pulse_flags(1, 0);
    chk(cur_ack && !s0 && ovr == 8'd1, "R6", "busy trigger refused", int'(ovr), 1);
    settle();
    list_shot(); settle();
    chk(eol_seen == 4, "R4", "eol count", eol_seen, 4);
    chk(r1 == adc_val(1, 26), "R8", "res1 last conv1", int'(r1), int'(adc_val(1, 26)));

    // R7: simultaneous flags, current wins
    exp_q.push_back({1'b0, 5'd8, adc_val(0, 8)});
    pulse_flags(1, 1);
    chk(cur_ack && list_ack && s0 && !s1 && c0 == 5'd8, "R7", "current wins", int'(s1), 0);
    chk(ovr == 8'd2, "R7", "list counted overrun", int'(ovr), 2);
    settle();
    list_sel = 0;
    list_shot(); settle();              // pointer still at item0
    list_shot(); settle();

    // R10: stray done from idle converter 1
    stray1 = 1; @(negedge clk); stray1 = 0;
    @(negedge clk);
    chk(r1 == adc_val(1, 24), "R10", "stray done ignored", int'(r1), int'(adc_val(1, 24)));
    chk(!fvalid, "R10", "stray done no push", int'(fvalid), 0);

    // R9: overflow
    settle();
    mon_en = 0;
    for (int k = 0; k < 4; k++) cur_shot(1);
    chk(!ovf, "R9", "no overflow at depth", int'(ovf), 0);
    cur_shot(0);
    chk(ovf, "R9", "overflow flag set", int'(ovf), 1);
    chk(r0 == adc_val(0, 8), "R9", "res0 still updated", int'(r0), int'(adc_val(0, 8)));
    mon_en = 1;
    settle();
    chk(exp_q.size() == 0, "R9", "kept entries drained", exp_q.size(), 0);
    chk(!fvalid && ovf, "R9", "fifo empty, flag sticky", int'(fvalid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule